// File: doc/BRIEF.md
# Write FIFO DMA request generator

This block sits on the write path of an external bus interface. A DMA engine pushes words into a small FIFO, and a bus sequencer drains them through a ready/valid pop port. One request line asks the single write DMA channel for more data. The line stays high while two things are true: part of a programmed transfer count is still outstanding, and the number of words held in storage is below a programmable threshold.

Software first loads the total number of words for the transfer and the fill threshold. Each word the FIFO accepts from the DMA lowers the remaining count by one. When the count reaches zero the request drops. When the FIFO is empty and the consumer is ready, an incoming word passes straight to the pop port and never occupies storage. Because of this, a burst of as many words as the threshold value can leave the request asserted. A raw trigger status bit mirrors the request. A sticky flag records any push that arrived while storage was full.

Top module: `wfifo_dma_req`

## Requirements
- R1: A write on the count port loads the remaining count on the next clock edge. This happens even if the count is non-zero, and the load takes priority over a decrement in the same cycle.
- R2: Each accepted push lowers the remaining count by one. A push accepted while the count is zero leaves it at zero, with no wrap.
- R3: `dma_req` is high exactly when the registered remaining count is non-zero and the registered storage level is below the registered threshold. It therefore reflects a load or a level change from the cycle after that change.
- R4: `trig_raw` equals `dma_req` in every cycle.
- R5: When storage is empty, `psh_valid` is high and `pop_ready` is high, the pushed word is handed to the pop port in the same cycle and the level stays 0.
- R6: Stored words leave the pop port in the order they were pushed.
- R7: A push while the level is 4 (full) is dropped and does not change the count. A simultaneous pop does not rescue it. It sets `ovf_sticky`, which stays high until reset.
- R8: `fifo_level` counts only stored words and stays within 0 to 4.
- R9: With threshold 4, load count 8, bypass one word and then store three words. After this, level is 3, count is 4, and `dma_req` stays high.
- R10: After reset: level 0, count 0, threshold 4, `dma_req` 0, `ovf_sticky` 0, and `pop_valid` 0 while no push is offered.
- R11: `pop_valid` is high when storage holds a word or a push is offered. `pop_data` is the oldest stored word, or the pushed word when storage is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_we | input | 1 | Load the remaining transfer count |
| cnt_wdata | input | 16 | Count value to load |
| thr_we | input | 1 | Load the fill threshold |
| thr_wdata | input | 3 | Threshold value, 0 to 4 meaningful |
| psh_valid | input | 1 | DMA offers a word |
| psh_data | input | 32 | Word offered by the DMA |
| pop_ready | input | 1 | Sequencer takes the presented word |
| pop_valid | output | 1 | A word is presented to the sequencer |
| pop_data | output | 32 | Word presented to the sequencer |
| dma_req | output | 1 | Request to the write DMA channel |
| trig_raw | output | 1 | Raw trigger status |
| ovf_sticky | output | 1 | A push was dropped while full |
| fifo_level | output | 3 | Number of words held in storage |
| tx_remaining | output | 16 | Words still owed by the DMA |

## Verification
Several properties are checked on every cycle. The level never exceeds four, and the overflow flag never falls. A bypassed word leaves the level at zero. A load lands one cycle later, while a plain accepted push decrements the count without wrapping. A zero count never coexists with a request. The bench scenarios cover what needs a history of stimulus. They show the data order across stores, bypasses and dropped pushes, and the request dropping once the level reaches the threshold. They also cover the four-word burst that leaves the trigger high, and a reload to zero cutting the request mid-transfer.

// File: rtl/wfd_pkg.sv
package wfd_pkg;

    localparam int unsigned WFD_DEPTH = 4;
    localparam int unsigned WFD_DW    = 32;
    localparam int unsigned WFD_CNT_W = 16;

    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,
        ACT_STORE = 2'd1,
        ACT_DRAIN = 2'd2,
        ACT_SWAP  = 2'd3
    } fifo_act_e;

    function automatic int unsigned lvl_width(input int unsigned depth);
        return $clog2(depth + 1);
    endfunction

    function automatic int unsigned ptr_width(input int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

    function automatic fifo_act_e pick_act(input logic store, input logic drain);
        return fifo_act_e'({drain, store});
    endfunction

endpackage

// File: rtl/wfd_fifo.sv
module wfd_fifo
    import wfd_pkg::*;
#(
    parameter int unsigned DW    = WFD_DW,
    parameter int unsigned DEPTH = WFD_DEPTH,
    localparam int unsigned LVL_W = lvl_width(DEPTH),
    localparam int unsigned PTR_W = ptr_width(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             psh_valid,
    input  logic [DW-1:0]    psh_data,
    input  logic             pop_ready,
    output logic             pop_valid,
    output logic [DW-1:0]    pop_data,
    output logic [LVL_W-1:0] level,
    output logic             push_acc,
    output logic             ovf
);

    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [DW-1:0]    slot [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             empty, full, bypass, store, drain;
    fifo_act_e        act;

    assign empty  = (level == '0);
    assign full   = (level == FULL_LVL);
    assign bypass = empty && psh_valid && pop_ready;
    assign store  = psh_valid && !full && !bypass;
    assign drain  = !empty && pop_ready;
    assign act    = pick_act(store, drain);

    assign push_acc  = psh_valid && !full;
    assign pop_valid = !empty || psh_valid;
    assign pop_data  = empty ? psh_data : slot[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
    endfunction

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (store && wr_ptr == PTR_W'(g)) begin
                    slot[g] <= psh_data;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (store) wr_ptr <= bump(wr_ptr);
            if (drain) rd_ptr <= bump(rd_ptr);
            unique case (act)
                ACT_STORE: level <= level + LVL_W'(1);
                ACT_DRAIN: level <= level - LVL_W'(1);
                default:   level <= level;
            endcase
            if (psh_valid && full) ovf <= 1'b1;
        end
    end

    assert_level_bound_R8: assert property (@(posedge clk) disable iff (rst)
        level <= FULL_LVL);
    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);
    assert_full_drop_R7: assert property (@(posedge clk) disable iff (rst)
        (full && psh_valid && !pop_ready) |=> (level == FULL_LVL) && ovf);
    assert_bypass_no_store_R5: assert property (@(posedge clk) disable iff (rst)
        (empty && psh_valid && pop_ready) |=> (level == '0));
    assert_pop_valid_R11: assert property (@(posedge clk) disable iff (rst)
        (level != '0) |-> pop_valid);

endmodule

// File: rtl/wfd_txcount.sv
module wfd_txcount
    import wfd_pkg::*;
#(
    parameter int unsigned CNT_W = WFD_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] remaining
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic has_work;
    assign has_work = (remaining != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            remaining <= '0;
        end else if (load) begin
            remaining <= load_val;
        end else if (dec && has_work) begin
            remaining <= remaining - ONE;
        end
    end

    assert_reload_R1: assert property (@(posedge clk) disable iff (rst)
        load |=> remaining == $past(load_val));
    assert_decrement_R2: assert property (@(posedge clk) disable iff (rst)
        (dec && !load && remaining != '0) |=> remaining == $past(remaining) - ONE);
    assert_no_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (remaining == '0 && !load) |=> remaining == '0);

endmodule

// File: rtl/wfd_trigger.sv
module wfd_trigger
    import wfd_pkg::*;
#(
    parameter int unsigned CNT_W = WFD_CNT_W,
    parameter int unsigned DEPTH = WFD_DEPTH,
    localparam int unsigned LVL_W = lvl_width(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             thr_we,
    input  logic [LVL_W-1:0] thr_wdata,
    input  logic [CNT_W-1:0] remaining,
    input  logic [LVL_W-1:0] level,
    output logic             trig
);

    logic [LVL_W-1:0] thresh_q;
    logic             owed, room;

    always_ff @(posedge clk) begin
        if (rst) begin
            thresh_q <= LVL_W'(DEPTH);
        end else if (thr_we) begin
            thresh_q <= thr_wdata;
        end
    end

    assign owed = (remaining != '0);
    assign room = (level < thresh_q);
    assign trig = owed && room;

    assert_req_drops_at_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (remaining == '0) |-> !trig);
    assert_req_blocked_when_full_R3: assert property (@(posedge clk) disable iff (rst)
        (level == LVL_W'(DEPTH)) |-> !trig);

endmodule

// File: rtl/wfifo_dma_req.sv
module wfifo_dma_req
    import wfd_pkg::*;
#(
    parameter int unsigned DW    = WFD_DW,
    parameter int unsigned DEPTH = WFD_DEPTH,
    parameter int unsigned CNT_W = WFD_CNT_W,
    localparam int unsigned LVL_W = lvl_width(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             thr_we,
    input  logic [LVL_W-1:0] thr_wdata,
    input  logic             psh_valid,
    input  logic [DW-1:0]    psh_data,
    input  logic             pop_ready,
    output logic             pop_valid,
    output logic [DW-1:0]    pop_data,
    output logic             dma_req,
    output logic             trig_raw,
    output logic             ovf_sticky,
    output logic [LVL_W-1:0] fifo_level,
    output logic [CNT_W-1:0] tx_remaining
);

    logic push_acc;
    logic trig;

    wfd_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .psh_valid (psh_valid),
        .psh_data  (psh_data),
        .pop_ready (pop_ready),
        .pop_valid (pop_valid),
        .pop_data  (pop_data),
        .level     (fifo_level),
        .push_acc  (push_acc),
        .ovf       (ovf_sticky)
    );

    wfd_txcount #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst       (rst),
        .load      (cnt_we),
        .load_val  (cnt_wdata),
        .dec       (push_acc),
        .remaining (tx_remaining)
    );

    wfd_trigger #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u_trig (
        .clk       (clk),
        .rst       (rst),
        .thr_we    (thr_we),
        .thr_wdata (thr_wdata),
        .remaining (tx_remaining),
        .level     (fifo_level),
        .trig      (trig)
    );

    assign dma_req  = trig;
    assign trig_raw = trig;

    assert_full_push_keeps_count_R7: assert property (@(posedge clk) disable iff (rst)
        (fifo_level == LVL_W'(DEPTH) && psh_valid && !cnt_we)
            |=> tx_remaining == $past(tx_remaining));
    assert_req_needs_owed_R3: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> (tx_remaining != '0));

endmodule

// File: tb/wfifo_dma_req_test.sv
module wfifo_dma_req_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE = 32'hC0DE_0000;

    typedef struct packed {
        logic        cw;
        logic [15:0] cv;
        logic        tw;
        logic [2:0]  tv;
        logic        pv;
        logic        pr;
        logic        chk;
        logic [7:0]  doff;
        logic [2:0]  e_lvl;
        logic [15:0] e_cnt;
        logic        e_req;
        logic        e_ovf;
    } vec_t;

    // push data of vector i is BASE + i
    localparam vec_t VEC [0:20] = '{
        '{1'b1, 16'd6, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 8'd0,  3'd0, 16'd6, 1'b1, 1'b0},
        '{1'b0, 16'd0, 1'b1, 3'd2, 1'b0, 1'b0, 1'b0, 8'd0,  3'd0, 16'd6, 1'b1, 1'b0},
        '{1'b0, 16'd0, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 8'd0,  3'd1, 16'd5, 1'b1, 1'b0},
        '{1'b0, 16'd0, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 8'd0,  3'd2, 16'd4, 1'b0, 1'b0},
        '{1'b0, 16'd0, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1, 8'd2,  3'd1, 16'd4, 1'b1, 1'b0},
        '{1'b0, 16'd0, 1'b0, 3'd0, 1'b1, 1'b1, 1'b1, 8'd3,  3'd1, 16'd3, 1'b1, 1'b0},
        '{1'b0, 16'd0, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1, 8'd5,  3'd0, 16'd3, 1'b1, 1'b0},
        '{1'b0, 16'd0, 1'b0, 3'd0, 1'b1, 1'b1, 1'b1, 8'd7,  3'd0, 16'd2, 1'b1, 1'b0},
        '{1'b0, 16'd0, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 8'd0,  3'd0, 16'd2, 1'b0, 1'b0},
        '{1'b0, 16'd0, 1'b1, 3'd3, 1'b1, 1'b0, 1'b0, 8'd0,  3'd1, 16'd1, 1'b1, 1'b0},
        '{1'b0, 16'd0, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 8'd0,  3'd2, 16'd0, 1'b0, 1'b0},
        '{1'b0, 16'd0, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 8'd0,  3'd3, 16'd0, 1'b0, 1'b0},
        '{1'b0, 16'd0, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 8'd0,  3'd4, 16'd0, 1'b0, 1'b0},
        '{1'b0, 16'd0, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 8'd0,  3'd4, 16'd0, 1'b0, 1'b1},
        '{1'b1, 16'd3, 1'b0, 3'd0, 1'b1, 1'b1, 1'b1, 8'd9,  3'd3, 16'd3, 1'b0, 1'b1},
        '{1'b0, 16'd0, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1, 8'd10, 3'd2, 16'd3, 1'b1, 1'b1},
        '{1'b0, 16'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 8'd0,  3'd2, 16'd3, 1'b1, 1'b1},
        '{1'b1, 16'd5, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 8'd0,  3'd3, 16'd5, 1'b0, 1'b1},
        '{1'b0, 16'd0, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1, 8'd11, 3'd2, 16'd5, 1'b1, 1'b1},
        '{1'b0, 16'd0, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1, 8'd12, 3'd1, 16'd5, 1'b1, 1'b1},
        '{1'b0, 16'd0, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1, 8'd17, 3'd0, 16'd5, 1'b1, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_we = 1'b0;
    logic [15:0] cnt_wdata = '0;
    logic        thr_we = 1'b0;
    logic [2:0]  thr_wdata = '0;
    logic        psh_valid = 1'b0;
    logic [31:0] psh_data = '0;
    logic        pop_ready = 1'b0;
    logic        pop_valid, dma_req, trig_raw, ovf_sticky;
    logic [31:0] pop_data;
    logic [2:0]  fifo_level;
    logic [15:0] tx_remaining;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wfifo_dma_req uut (
        .clk(clk), .rst(rst),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .thr_we(thr_we), .thr_wdata(thr_wdata),
        .psh_valid(psh_valid), .psh_data(psh_data),
        .pop_ready(pop_ready), .pop_valid(pop_valid), .pop_data(pop_data),
        .dma_req(dma_req), .trig_raw(trig_raw), .ovf_sticky(ovf_sticky),
        .fifo_level(fifo_level), .tx_remaining(tx_remaining)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic drive(input logic cw, input logic [15:0] cv, input logic tw,
                         input logic [2:0] tv, input logic pv, input logic [31:0] pd,
                         input logic pr);
        @(negedge clk);
        cnt_we = cw; cnt_wdata = cv; thr_we = tw; thr_wdata = tv;
        psh_valid = pv; psh_data = pd; pop_ready = pr;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cnt_we = 0; thr_we = 0; psh_valid = 0; pop_ready = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        #1;
        // R10 reset state
        check("R10 level", 32'(fifo_level), 32'd0);
        check("R10 count", 32'(tx_remaining), 32'd0);
        check("R10 req", 32'(dma_req), 32'd0);
        check("R10 ovf", 32'(ovf_sticky), 32'd0);
        check("R10 pop_valid idle (R11)", 32'(pop_valid), 32'd0);

        // table walk: R1 R2 R3 R4 R5 R6 R7 R8 R11
        for (int i = 0; i < 21; i++) begin
            drive(VEC[i].cw, VEC[i].cv, VEC[i].tw, VEC[i].tv, VEC[i].pv,
                  BASE + 32'(i), VEC[i].pr);
            if (VEC[i].chk) begin
                check($sformatf("R6 R11 pop_valid v%0d", i), 32'(pop_valid), 32'd1);
                check($sformatf("R6 R5 pop_data v%0d", i), pop_data, BASE + 32'(VEC[i].doff));
            end
            @(posedge clk);
            #1;
            check($sformatf("R8 R5 level v%0d", i), 32'(fifo_level), 32'(VEC[i].e_lvl));
            check($sformatf("R1 R2 count v%0d", i), 32'(tx_remaining), 32'(VEC[i].e_cnt));
            check($sformatf("R3 req v%0d", i), 32'(dma_req), 32'(VEC[i].e_req));
            check($sformatf("R4 trig_raw v%0d", i), 32'(trig_raw), 32'(dma_req));
            check($sformatf("R7 ovf v%0d", i), 32'(ovf_sticky), 32'(VEC[i].e_ovf));
        end
        drive(0, 0, 0, 0, 0, 0, 0);
        check("R11 pop_valid drained", 32'(pop_valid), 32'd0);

        // R9 threshold 4, burst of four with the first word bypassed
        do_reset();
        drive(1, 16'd8, 0, 0, 0, 0, 0);
        @(posedge clk); #1;
        drive(0, 0, 0, 0, 1, 32'hB000_0000, 1);
        check("R9 R5 bypass data", pop_data, 32'hB000_0000);
        @(posedge clk); #1;
        check("R9 R5 bypass level", 32'(fifo_level), 32'd0);
        for (int k = 1; k < 4; k++) begin
            drive(0, 0, 0, 0, 1, 32'hB000_0000 + 32'(k), 0);
            @(posedge clk); #1;
        end
        check("R9 level", 32'(fifo_level), 32'd3);
        check("R9 count", 32'(tx_remaining), 32'd4);
        check("R9 req stays high", 32'(dma_req), 32'd1);
        check("R9 R4 trig_raw", 32'(trig_raw), 32'd1);

        // R1 reload while non-zero, then reload to zero drops request (R3)
        drive(1, 16'd2, 0, 0, 0, 0, 0);
        check("R3 req before reload edge", 32'(dma_req), 32'd1);
        @(posedge clk); #1;
        check("R1 reload", 32'(tx_remaining), 32'd2);
        drive(1, 16'd0, 0, 0, 0, 0, 0);
        check("R3 req unchanged until edge", 32'(dma_req), 32'd1);
        @(posedge clk); #1;
        check("R1 reload zero", 32'(tx_remaining), 32'd0);
        check("R3 req drops", 32'(dma_req), 32'd0);
        drive(0, 0, 0, 0, 0, 0, 1);
        check("R6 burst order", pop_data, 32'hB000_0001);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule